// File: doc/BRIEF.md
# Timer Expiry Interrupt Router

This block sits between a set of timer comparators and the interrupt fabric. For every timer channel it holds a 64-bit configuration word and a 64-bit message register. When a channel's expiry strobe arrives, the block picks one of three ways to deliver it. It can issue a message write whose address and data come from the message register. It can send a one-cycle pulse on an advanced interrupt-controller pin. It can also hold a level on such a pin until the level is released.

A global legacy-replacement input overrides timers 0 and 1. Timer 0 is then wired to advanced pin 2 and legacy-controller pin 0, and timer 1 to advanced pin 8 and legacy-controller pin 8. Both always act as edge sources and never use message delivery.

Level-type channels keep a status bit. Software clears it with a write-1 strobe, and the block also clears it when a configuration write makes the held level stale. Any requested route whose bit is missing from the channel's read-only allowed-pin mask is refused.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset every configuration word reads `{ALLOW, 32'h0000_8010}`: bit 15 is message-capable = 1, bit 4 is periodic-capable = 1, and every writable bit is 0. With the default 24 pins, `ALLOW` = 0x00F00000. All status bits and all outputs are 0.
- R2: Only bits 1 (level type), 2 (enable), 3 (periodic), 13:9 (route) and 14 (message enable) are writable. Bits 63:32, 15, 4, 5 and 8 ignore writes, and bit 8 always reads 0.
- R3: If a written route is non-zero and its bit in the allowed mask (word bit 32+route) is 0, the route field is stored as 0. Allowed routes are stored unchanged.
- R4: An enabled edge channel (bit 1 = 0) with a non-zero route p, on an expiry, raises `apic_pulse[p]` for exactly the one cycle after the expiry cycle.
- R5: An enabled level channel (bit 1 = 1) with a non-zero route p, on an expiry, sets its status bit. From the next cycle `apic_level[p]` stays high until the status is cleared.
- R6: An expiry on a channel with bit 2 = 0 causes no output or status change.
- R7: An expiry on a channel whose status bit is already set (and not cleared in that cycle) produces nothing new.
- R8: A non-legacy, non-message channel with route 0 produces no pin activity on expiry.
- R9: With bits 14 and 15 both set (outside legacy override), an expiry raises `msg_valid` for one cycle, with `msg_addr` = message register bits 63:32 and `msg_data` = bits 31:0. No pin or status activity results. When several channels fire in the same cycle, the lowest index wins.
- R10: With `legacy_en` = 1, timer 0 pulses `apic_pulse[2]` and `pic_pulse[0]`, and timer 1 pulses `apic_pulse[8]` and `pic_pulse[8]`. This happens even when the channel is set to level or message delivery. `pic_pulse` is otherwise 0.
- R11: `stat_clr[t]` = 1 clears status bit t and releases its pin. If an expiry on that channel lands in the same cycle, the expiry wins and the status stays set.
- R12: A configuration write clears a set status bit when the new word disables the interrupt, selects edge type, selects message delivery, or changes the effective route. Other changes, such as the periodic bit, leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_en | input | 1 | Legacy-replacement override for timers 0 and 1 |
| expire | input | NT | Per-channel expiry strobes |
| stat_clr | input | NT | Write-1-to-clear for status bits |
| sel | input | SW | Channel addressed by writes and readback |
| cfg_wr | input | 1 | Write `wdata` into the selected configuration word |
| rt_wr | input | 1 | Write `wdata` into the selected message register |
| wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Configuration word of the selected channel |
| status | output | NT | Level status bits |
| apic_pulse | output | NPIN | One-cycle pulses on advanced-controller pins |
| apic_level | output | NPIN | Held levels on advanced-controller pins |
| pic_pulse | output | NLEG | One-cycle pulses on legacy-controller pins |
| msg_valid | output | 1 | Message write request |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Two functions can act on the same status bit in the same cycle. One is the software clear strobe. The other is a fresh expiry of that level channel, which may arrive while the bit is set. The bench drives both in one cycle on a channel whose status is already set. It expects the status and the held pin to remain asserted afterwards, because the new event must not be lost. It also separately confirms that the clear alone drops them.

// File: rtl/tmr_irq_router.sv
module tmr_irq_router #(
  parameter int NT = 4,
  parameter int NPIN = 24,
  parameter int NLEG = 16,
  parameter logic [31:0] ALLOW = (NPIN >= 24) ? 32'h00F0_0000 : 32'h0,
  localparam int SW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            legacy_en,
  input  logic [NT-1:0]   expire,
  input  logic [NT-1:0]   stat_clr,
  input  logic [SW-1:0]   sel,
  input  logic            cfg_wr,
  input  logic            rt_wr,
  input  logic [63:0]     wdata,
  output logic [63:0]     cfg_rdata,
  output logic [NT-1:0]   status,
  output logic [NPIN-1:0] apic_pulse,
  output logic [NPIN-1:0] apic_level,
  output logic [NLEG-1:0] pic_pulse,
  output logic            msg_valid,
  output logic [31:0]     msg_addr,
  output logic [31:0]     msg_data
);
  localparam logic [63:0] WMASK = 64'h0000_0000_0000_7E0E;
  localparam logic [63:0] CFG0  = {ALLOW, 32'h0000_8010};

  logic [NT-1:0][63:0] cfg_q, rt_q;
  logic [NT-1:0][4:0]  lpin_q, pin_of;
  logic [NT-1:0]       is_msg, go, lvl_go, pls_go, n_clr;
  logic [NPIN-1:0]     ap_n;
  logic [NLEG-1:0]     pp_n;
  logic                mv_n;
  logic [63:0]         mw_n;

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] d);
    logic [63:0] m;
    m = (o & ~WMASK) | (d & WMASK);
    if (m[13:9] != 5'd0 && !m[32 + int'(m[13:9])]) m[13:9] = 5'd0;
    return m;
  endfunction

  // returns {message, edge, pin}
  function automatic logic [6:0] route(input logic [63:0] c, input logic leg, input logic first);
    logic msg;
    logic [4:0] pin;
    msg = !leg && c[14] && c[15];
    pin = msg ? 5'd0 : leg ? (first ? 5'd2 : 5'd8) : c[13:9];
    return {msg, leg || !c[1], pin};
  endfunction

  always_comb begin
    ap_n = '0; pp_n = '0; mv_n = 1'b0; mw_n = '0;
    for (int t = 0; t < NT; t++) begin
      logic leg, wr_t;
      logic [6:0] cur, nxt;
      logic [63:0] nc;
      leg = legacy_en && (t < 2);
      wr_t = cfg_wr && (sel == SW'(t));
      cur = route(cfg_q[t], leg, t == 0);
      nc = merge(cfg_q[t], wdata);
      nxt = route(nc, leg, t == 0);
      is_msg[t] = cur[6];
      pin_of[t] = cur[4:0];
      go[t] = expire[t] && cfg_q[t][2] && !(status[t] && !stat_clr[t]);
      pls_go[t] = go[t] && !cur[6] && cur[4:0] != 5'd0 && cur[5];
      lvl_go[t] = go[t] && !cur[6] && cur[4:0] != 5'd0 && !cur[5];
      n_clr[t] = wr_t && status[t] &&
                 (!nc[2] || nxt[6] || nxt[5] || nxt[4:0] != lpin_q[t]);
      if (pls_go[t] && int'(cur[4:0]) < NPIN) ap_n[cur[4:0]] = 1'b1;
      if (pls_go[t] && leg) pp_n[(t == 0) ? 0 : 8] = 1'b1;
    end
    for (int t = NT - 1; t >= 0; t--)
      if (go[t] && is_msg[t]) begin
        mv_n = 1'b1;
        mw_n = rt_q[t];
      end
  end

  always_comb begin
    apic_level = '0;
    for (int t = 0; t < NT; t++)
      if (status[t] && int'(lpin_q[t]) < NPIN) apic_level[lpin_q[t]] = 1'b1;
  end

  assign cfg_rdata = cfg_q[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= {NT{CFG0}};
      rt_q <= '0;
      lpin_q <= '0;
      status <= '0;
      apic_pulse <= '0;
      pic_pulse <= '0;
      msg_valid <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (cfg_wr && sel == SW'(t)) cfg_q[t] <= merge(cfg_q[t], wdata);
        if (rt_wr && sel == SW'(t)) rt_q[t] <= wdata;
        if (lvl_go[t]) lpin_q[t] <= pin_of[t];
      end
      status <= (status & ~stat_clr & ~n_clr) | lvl_go;
      apic_pulse <= ap_n;
      pic_pulse <= pp_n;
      msg_valid <= mv_n;
      if (mv_n) begin
        msg_addr <= mw_n[63:32];
        msg_data <= mw_n[31:0];
      end
    end
  end
endmodule

module tmr_irq_router_chk #(
  parameter int NT = 4,
  parameter int NPIN = 24,
  parameter int NLEG = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            legacy_en,
  input logic [NT-1:0]   expire,
  input logic [NT-1:0]   status,
  input logic [NPIN-1:0] apic_pulse,
  input logic [NPIN-1:0] apic_level,
  input logic [NLEG-1:0] pic_pulse,
  input logic            msg_valid,
  input logic [63:0]     cfg_rdata
);
  a_r4_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|apic_pulse) |-> $past(|expire));
  a_r9_msg_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(|expire));
  a_r5_status_rise_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) != '0) |-> $past(|expire));
  a_r11_no_level_without_status: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> (apic_level == '0));
  a_r5_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(apic_level) <= $countones(status));
  a_r10_pic_legacy_only: assert property (@(posedge clk) disable iff (!rst_n)
    (|pic_pulse) |-> ($past(legacy_en) && (pic_pulse & ~NLEG'(16'h0101)) == '0));
  a_r2_size_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[8] && !cfg_rdata[5] && cfg_rdata[15] && cfg_rdata[4]);
endmodule

bind tmr_irq_router tmr_irq_router_chk #(.NT(NT), .NPIN(NPIN), .NLEG(NLEG)) u_chk (.*);

// File: tb/sim_tmr_irq_router.sv
`timescale 1ns/1ps
module sim_tmr_irq_router;
  logic clk = 0, rst_n = 0, legacy_en = 0, cfg_wr = 0, rt_wr = 0;
  logic [3:0] expire = 0, stat_clr = 0, status;
  logic [1:0] sel = 0;
  logic [63:0] wdata = 0, cfg_rdata;
  logic [23:0] apic_pulse, apic_level;
  logic [15:0] pic_pulse;
  logic msg_valid;
  logic [31:0] msg_addr, msg_data;

  tmr_irq_router u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    string tag; int due;
    logic [23:0] ap, al; logic [15:0] pp; logic [3:0] st;
    logic mv; logic [31:0] ma, md; logic chk; logic [63:0] rd;
  } exp_t;

  exp_t q[$];
  int cyc = 0, nrun = 0, nfail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      nrun++;
      bad = apic_pulse !== e.ap || apic_level !== e.al || pic_pulse !== e.pp ||
            status !== e.st || msg_valid !== e.mv ||
            (e.mv && (msg_addr !== e.ma || msg_data !== e.md)) ||
            (e.chk && cfg_rdata !== e.rd);
      if (bad) begin
        nfail++;
        $display("FAIL %s: got ap=%h al=%h pp=%h st=%h mv=%b ma=%h md=%h rd=%h exp ap=%h al=%h pp=%h st=%h mv=%b ma=%h md=%h rd=%h",
          e.tag, apic_pulse, apic_level, pic_pulse, status, msg_valid, msg_addr, msg_data, cfg_rdata,
          e.ap, e.al, e.pp, e.st, e.mv, e.ma, e.md, e.rd);
      end
    end

  function automatic exp_t mk(string tag, logic [23:0] ap, logic [23:0] al, logic [15:0] pp,
                              logic [3:0] st, logic mv, logic [31:0] ma, logic [31:0] md,
                              logic chk, logic [63:0] rd);
    exp_t e;
    e.tag = tag; e.due = 0; e.ap = ap; e.al = al; e.pp = pp; e.st = st;
    e.mv = mv; e.ma = ma; e.md = md; e.chk = chk; e.rd = rd;
    return e;
  endfunction

  task automatic step(input logic [3:0] ex, input logic [3:0] clr, input logic cw, input logic rw,
                      input logic [1:0] s, input logic [63:0] wd, input logic lg, input exp_t e);
    expire = ex; stat_clr = clr; cfg_wr = cw; rt_wr = rw; sel = s; wdata = wd; legacy_en = lg;
    e.due = cyc + 1;
    q.push_back(e);
    @(posedge clk); #2;
    expire = 0; stat_clr = 0; cfg_wr = 0; rt_wr = 0;
  endtask

  localparam logic [63:0] HI = 64'h00F0_0000_0000_0000;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, mk("R1 reset", 0, 0, 0, 0, 0, 0, 0, 1, HI | 64'h8010));
    step(0, 0, 1, 0, 0, '1, 0, mk("R2 read-only bits", 0, 0, 0, 0, 0, 0, 0, 1, HI | 64'hC01E));
    step(0, 0, 1, 0, 0, 64'h0204, 0, mk("R3 route 1 refused", 0, 0, 0, 0, 0, 0, 0, 1, HI | 64'h8014));
    step(0, 0, 1, 0, 0, 64'h2A04, 0, mk("R3 route 21 kept", 0, 0, 0, 0, 0, 0, 0, 1, HI | 64'hAA14));
    step(1, 0, 0, 0, 0, 0, 0, mk("R4 edge pulse", 24'h1 << 21, 0, 0, 0, 0, 0, 0, 0, 0));
    step(0, 0, 0, 0, 0, 0, 0, mk("R4 pulse ends", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0, 0, 64'h2A00, 0, mk("R6 disable write", 0, 0, 0, 0, 0, 0, 0, 1, HI | 64'hAA10));
    step(1, 0, 0, 0, 0, 0, 0, mk("R6 disabled expiry", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0, 1, 64'h0004, 0, mk("R8 unrouted write", 0, 0, 0, 0, 0, 0, 0, 1, HI | 64'h8014));
    step(2, 0, 0, 0, 1, 0, 0, mk("R8 unrouted expiry", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0, 2, 64'h2C06, 0, mk("R5 level write", 0, 0, 0, 0, 0, 0, 0, 1, HI | 64'hAC16));
    step(4, 0, 0, 0, 2, 0, 0, mk("R5 level set", 0, 24'h1 << 22, 0, 4, 0, 0, 0, 0, 0));
    step(0, 0, 0, 0, 2, 0, 0, mk("R5 level held", 0, 24'h1 << 22, 0, 4, 0, 0, 0, 0, 0));
    step(4, 0, 0, 0, 2, 0, 0, mk("R7 repeat ignored", 0, 24'h1 << 22, 0, 4, 0, 0, 0, 0, 0));
    step(0, 4, 0, 0, 2, 0, 0, mk("R11 clear", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(4, 0, 0, 0, 2, 0, 0, mk("R5 set again", 0, 24'h1 << 22, 0, 4, 0, 0, 0, 0, 0));
    step(4, 4, 0, 0, 2, 0, 0, mk("R11 clear vs expiry", 0, 24'h1 << 22, 0, 4, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0, 2, 64'h2C0E, 0, mk("R12 periodic keeps", 0, 24'h1 << 22, 0, 4, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0, 2, 64'h2E0E, 0, mk("R12 route change", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(4, 0, 0, 0, 2, 0, 0, mk("R5 route 23", 0, 24'h1 << 23, 0, 4, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0, 2, 64'h2E0C, 0, mk("R12 to edge", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0, 2, 64'h2E0E, 0, mk("R12 back to level", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(4, 0, 0, 0, 2, 0, 0, mk("R5 set 23", 0, 24'h1 << 23, 0, 4, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0, 2, 64'h2E0A, 0, mk("R12 disable", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0, 2, 64'h2E0E, 0, mk("R12 re-enable", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(4, 0, 0, 0, 2, 0, 0, mk("R5 set 23b", 0, 24'h1 << 23, 0, 4, 0, 0, 0, 0, 0));
    step(0, 0, 1, 0, 2, 64'h6E0E, 0, mk("R12 to message", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(0, 0, 0, 1, 2, 64'h1234_5678_9ABC_DEF0, 0, mk("R9 load msg", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(4, 0, 0, 0, 2, 0, 0, mk("R9 message", 0, 0, 0, 0, 1, 32'h1234_5678, 32'h9ABC_DEF0, 0, 0));
    step(0, 0, 1, 0, 3, 64'h4004, 0, mk("R9 ch3 cfg", 0, 0, 0, 0, 0, 0, 0, 1, HI | 64'hC014));
    step(0, 0, 0, 1, 3, 64'hAAAA_0000_0000_0001, 0, mk("R9 ch3 msg", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(4'hC, 0, 0, 0, 3, 0, 0, mk("R9 lowest wins", 0, 0, 0, 0, 1, 32'h1234_5678, 32'h9ABC_DEF0, 0, 0));
    step(8, 0, 0, 0, 3, 0, 0, mk("R9 ch3 alone", 0, 0, 0, 0, 1, 32'hAAAA_0000, 32'h1, 0, 0));
    step(0, 0, 1, 0, 0, 64'h4006, 1, mk("R10 legacy cfg", 0, 0, 0, 0, 0, 0, 0, 0, 0));
    step(1, 0, 0, 0, 0, 0, 1, mk("R10 timer0", 24'h1 << 2, 0, 16'h0001, 0, 0, 0, 0, 0, 0));
    step(2, 0, 0, 0, 0, 0, 1, mk("R10 timer1", 24'h1 << 8, 0, 16'h0100, 0, 0, 0, 0, 0, 0));
    step(3, 0, 0, 0, 0, 0, 1, mk("R10 both", 24'h104, 0, 16'h0101, 0, 0, 0, 0, 0, 0));
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      nrun++; nfail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end
endmodule